// File: doc/BRIEF.md
# Global Counter with Auto-Increment Comparator

This block keeps a 64-bit free-running time base and one 64-bit compare value. Software reaches both through a 32-bit register port, so each 64-bit quantity is written and read as a lower and an upper word. The counter advances by one on each pulse of a count-enable tick input while the run bit is set, and it wraps modulo 2^64. When the enabled comparator equals the counter, a sticky event flag is raised and, if unmasked, drives the interrupt output.

In auto-increment mode, each match adds a programmed 32-bit step to the compare value, so a single setup produces a stream of events at a fixed period with no software re-arming. Every write to a counter word, comparator word, step register or control register is acknowledged by a sticky write-status bit, which software polls and then clears by writing one. The two counter words are not captured together. A reader that needs all 64 bits reads upper, lower and upper again, and retries if the two upper reads differ.

Top module: `gct_timer`

## Requirements
- R1: After reset the counter, comparator, step, control, interrupt status, interrupt enable and both write-status registers read 0, and `irq_o` is low.
- R2: The counter (words at 0x100 lower, 0x104 upper) increments by exactly one for each cycle in which `tick_i` is high while the run bit (bit 8 of the control register at 0x240) is set. While the run bit is clear, ticks have no effect.
- R3: A write to 0x100 or 0x104 replaces that counter word at the next clock edge, and the tick in that cycle is dropped. Incrementing from all ones yields all zeros in both words.
- R4: The two counter words are read live and are not captured together. A carry out of the lower word is visible in the upper word at the next read, so an upper/lower/upper read sequence can see the upper word change.
- R5: While the compare-enable bit (control bit 0) is set and the counter equals the comparator (0x200 lower, 0x204 upper), bit 0 of the interrupt status at 0x244 is set at the next edge. It then stays set until it is cleared.
- R6: Writing a value with bit 0 = 1 to 0x244 clears the status bit, and writing bit 0 = 0 leaves it unchanged. A match in the same cycle as the clear takes priority.
- R7: `irq_o` is high exactly when the status bit and the enable bit (0x248 bit 0) are both set. It rises in the cycle after the match cycle, and clearing the enable masks it.
- R8: With auto-increment (control bit 1) and compare enable both set, each match adds the step register (0x208, zero-extended) to the comparator at the same edge that sets the status, so matches recur every step ticks.
- R9: With the compare-enable bit clear, counter equality neither sets the status nor moves the comparator.
- R10: At the edge that applies the write, a write-status bit is set and is then readable in the next cycle. At 0x110, bit 0 is set by lower-counter writes and bit 1 by upper-counter writes. At 0x24C, bit 0 is set by comparator-lower writes, bit 1 by comparator-upper, bit 2 by the step register and bit 16 by the control register. Each bit is sticky and is cleared by writing 1 to it. Writing 0 to a bit leaves it unchanged.
- R11: The control register stores and reads back only bits 8, 1 and 0. Other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable pulse, one increment per high cycle |
| we_i | input | 1 | Register write strobe |
| addr_i | input | AW (12) | Register byte offset |
| wdata_i | input | DW (32) | Write data |
| rdata_o | output | DW (32) | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt, status AND enable |

## Verification
Register writes, counter increments and write-status bits all appear at the edge that samples the strobe or tick. The bench drives on the falling edge and reads half a cycle later, so each result is checked in the cycle after its stimulus. The interrupt status and `irq_o` need one more edge, because the match is found only once the counter already equals the comparator. The bench therefore checks that `irq_o` is still low right after the tick that reaches the compare value, and high one cycle later. The auto-increment comparator is read back in the same cycle as the status it belongs to.

// File: rtl/gct_pkg.sv
package gct_pkg;
    // Register byte offsets
    localparam int unsigned OFF_CNT_LO  = 32'h100;
    localparam int unsigned OFF_CNT_HI  = 32'h104;
    localparam int unsigned OFF_CNT_WS  = 32'h110;
    localparam int unsigned OFF_CMP_LO  = 32'h200;
    localparam int unsigned OFF_CMP_HI  = 32'h204;
    localparam int unsigned OFF_STEP    = 32'h208;
    localparam int unsigned OFF_CTRL    = 32'h240;
    localparam int unsigned OFF_ISTAT   = 32'h244;
    localparam int unsigned OFF_IEN     = 32'h248;
    localparam int unsigned OFF_GEN_WS  = 32'h24C;

    // Control bit positions
    localparam int unsigned CTRL_EN_BIT  = 0;
    localparam int unsigned CTRL_AI_BIT  = 1;
    localparam int unsigned CTRL_RUN_BIT = 8;

    // General write-status bit positions
    localparam int unsigned GWS_CMP_LO_BIT = 0;
    localparam int unsigned GWS_CMP_HI_BIT = 1;
    localparam int unsigned GWS_STEP_BIT   = 2;
    localparam int unsigned GWS_CTRL_BIT   = 16;

    // Decoded write strobes
    typedef struct packed {
        logic cnt_lo;
        logic cnt_hi;
        logic cnt_ws;
        logic cmp_lo;
        logic cmp_hi;
        logic step;
        logic ctrl;
        logic istat;
        logic ien;
        logic gen_ws;
    } wr_strobe_t;
endpackage

// File: rtl/gct_counter.sv
module gct_counter #(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tick,
    input  logic            run,
    input  logic            wr_lo,
    input  logic            wr_hi,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cnt
);
    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_lo || wr_hi) begin
            if (wr_lo) st_d.cnt[DW-1:0]  = wdata;
            if (wr_hi) st_d.cnt[CW-1:DW] = wdata;
        end else if (run && tick) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/gct_compare.sv
module gct_compare
    import gct_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [2*DW-1:0] cnt,
    input  wr_strobe_t      wr,
    input  logic [DW-1:0]   wdata,
    output logic [2*DW-1:0] cmp,
    output logic [DW-1:0]   step,
    output logic            run,
    output logic            auto_inc,
    output logic            cmp_en,
    output logic            int_stat,
    output logic            int_en,
    output logic            irq
);
    localparam int CW = 2 * DW;

    typedef struct packed {
        logic [CW-1:0] cmp;
        logic [DW-1:0] step;
        logic          run;
        logic          ai;
        logic          en;
        logic          ist;
        logic          ien;
    } cmp_state_t;

    cmp_state_t st_d, st_q;
    logic       match;

    always_comb begin
        st_d  = st_q;
        match = st_q.en && (cnt == st_q.cmp);

        if (match && st_q.ai)
            st_d.cmp = st_q.cmp + {{DW{1'b0}}, st_q.step};
        if (wr.cmp_lo) st_d.cmp[DW-1:0]  = wdata;
        if (wr.cmp_hi) st_d.cmp[CW-1:DW] = wdata;

        if (wr.step) st_d.step = wdata;
        if (wr.ctrl) begin
            st_d.run = wdata[CTRL_RUN_BIT];
            st_d.ai  = wdata[CTRL_AI_BIT];
            st_d.en  = wdata[CTRL_EN_BIT];
        end
        if (wr.ien) st_d.ien = wdata[0];

        if (wr.istat && wdata[0]) st_d.ist = 1'b0;
        if (match)                st_d.ist = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cmp      = st_q.cmp;
    assign step     = st_q.step;
    assign run      = st_q.run;
    assign auto_inc = st_q.ai;
    assign cmp_en   = st_q.en;
    assign int_stat = st_q.ist;
    assign int_en   = st_q.ien;
    assign irq      = st_q.ist & st_q.ien;
endmodule

// File: rtl/gct_wstat.sv
module gct_wstat
    import gct_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wr_strobe_t    wr,
    input  logic [1:0]    cnt_clr_bits,
    input  logic [3:0]    gen_clr_bits,
    output logic [1:0]    cnt_ws,
    output logic [DW-1:0] gen_ws
);
    localparam int NGEN = 4;

    typedef struct packed {
        logic [1:0]      cws;
        logic [NGEN-1:0] gws;
    } ws_state_t;

    ws_state_t       st_d, st_q;
    logic [NGEN-1:0] gen_set;

    always_comb begin
        gen_set = {wr.ctrl, wr.step, wr.cmp_hi, wr.cmp_lo};
        st_d = st_q;
        if (wr.cnt_ws) st_d.cws = st_d.cws & ~cnt_clr_bits;
        if (wr.gen_ws) st_d.gws = st_d.gws & ~gen_clr_bits;
        st_d.cws = st_d.cws | {wr.cnt_hi, wr.cnt_lo};
        st_d.gws = st_d.gws | gen_set;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        gen_ws                 = '0;
        gen_ws[GWS_CMP_LO_BIT] = st_q.gws[0];
        gen_ws[GWS_CMP_HI_BIT] = st_q.gws[1];
        gen_ws[GWS_STEP_BIT]   = st_q.gws[2];
        gen_ws[GWS_CTRL_BIT]   = st_q.gws[3];
    end

    assign cnt_ws = st_q.cws;
endmodule

// File: rtl/gct_timer.sv
module gct_timer
    import gct_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          we_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o,
    output logic          irq_o
);
    localparam int CW = 2 * DW;

    wr_strobe_t    wr;
    logic [CW-1:0] cnt_val;
    logic [CW-1:0] cmp_val;
    logic [DW-1:0] step_val;
    logic          ctrl_start;
    logic          ctrl_ai;
    logic          ctrl_en;
    logic          int_stat;
    logic          int_en;
    logic [1:0]    cnt_ws;
    logic [DW-1:0] gen_ws;

    always_comb begin
        wr        = '0;
        wr.cnt_lo = we_i && (addr_i == AW'(OFF_CNT_LO));
        wr.cnt_hi = we_i && (addr_i == AW'(OFF_CNT_HI));
        wr.cnt_ws = we_i && (addr_i == AW'(OFF_CNT_WS));
        wr.cmp_lo = we_i && (addr_i == AW'(OFF_CMP_LO));
        wr.cmp_hi = we_i && (addr_i == AW'(OFF_CMP_HI));
        wr.step   = we_i && (addr_i == AW'(OFF_STEP));
        wr.ctrl   = we_i && (addr_i == AW'(OFF_CTRL));
        wr.istat  = we_i && (addr_i == AW'(OFF_ISTAT));
        wr.ien    = we_i && (addr_i == AW'(OFF_IEN));
        wr.gen_ws = we_i && (addr_i == AW'(OFF_GEN_WS));
    end

    gct_counter #(.DW(DW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick_i),
        .run   (ctrl_start),
        .wr_lo (wr.cnt_lo),
        .wr_hi (wr.cnt_hi),
        .wdata (wdata_i),
        .cnt   (cnt_val)
    );

    gct_compare #(.DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt_val),
        .wr       (wr),
        .wdata    (wdata_i),
        .cmp      (cmp_val),
        .step     (step_val),
        .run      (ctrl_start),
        .auto_inc (ctrl_ai),
        .cmp_en   (ctrl_en),
        .int_stat (int_stat),
        .int_en   (int_en),
        .irq      (irq_o)
    );

    gct_wstat #(.DW(DW)) u_ws (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr           (wr),
        .cnt_clr_bits (wdata_i[1:0]),
        .gen_clr_bits ({wdata_i[GWS_CTRL_BIT], wdata_i[GWS_STEP_BIT],
                        wdata_i[GWS_CMP_HI_BIT], wdata_i[GWS_CMP_LO_BIT]}),
        .cnt_ws       (cnt_ws),
        .gen_ws       (gen_ws)
    );

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            AW'(OFF_CNT_LO): rdata_o = cnt_val[DW-1:0];
            AW'(OFF_CNT_HI): rdata_o = cnt_val[CW-1:DW];
            AW'(OFF_CNT_WS): rdata_o = {{(DW-2){1'b0}}, cnt_ws};
            AW'(OFF_CMP_LO): rdata_o = cmp_val[DW-1:0];
            AW'(OFF_CMP_HI): rdata_o = cmp_val[CW-1:DW];
            AW'(OFF_STEP):   rdata_o = step_val;
            AW'(OFF_CTRL): begin
                rdata_o[CTRL_RUN_BIT] = ctrl_start;
                rdata_o[CTRL_AI_BIT]  = ctrl_ai;
                rdata_o[CTRL_EN_BIT]  = ctrl_en;
            end
            AW'(OFF_ISTAT):  rdata_o[0] = int_stat;
            AW'(OFF_IEN):    rdata_o[0] = int_en;
            AW'(OFF_GEN_WS): rdata_o = gen_ws;
            default:         rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gct_checker.sv
module gct_checker
    import gct_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            tick_i,
    input logic            we_i,
    input logic [AW-1:0]   addr_i,
    input logic [DW-1:0]   wdata_i,
    input logic [2*DW-1:0] cnt_val,
    input logic [2*DW-1:0] cmp_val,
    input logic [DW-1:0]   step_val,
    input logic            ctrl_start,
    input logic            ctrl_ai,
    input logic            ctrl_en,
    input logic            int_stat,
    input logic [1:0]      cnt_ws
);
    localparam int CW = 2 * DW;

    logic cnt_write, cmp_write, stat_clear;
    assign cnt_write  = we_i && (addr_i == AW'(OFF_CNT_LO) || addr_i == AW'(OFF_CNT_HI));
    assign cmp_write  = we_i && (addr_i == AW'(OFF_CMP_LO) || addr_i == AW'(OFF_CMP_HI));
    assign stat_clear = we_i && (addr_i == AW'(OFF_ISTAT)) && wdata_i[0];

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_start && !cnt_write) |=> $stable(cnt_val)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_start && tick_i && !cnt_write) |=> (cnt_val == $past(cnt_val) + CW'(1))); // R2
    AST_MATCH_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && cnt_val == cmp_val) |=> int_stat); // R5
    AST_STAT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (int_stat && !stat_clear) |=> int_stat); // R5
    AST_AUTO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_en && ctrl_ai && cnt_val == cmp_val && !cmp_write)
        |=> (cmp_val == $past(cmp_val) + CW'($past(step_val)))); // R8
    AST_NO_MATCH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_en && !int_stat) |=> !int_stat); // R9
    AST_CNT_WS_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && addr_i == AW'(OFF_CNT_LO)) |=> cnt_ws[0]); // R10
endmodule

bind gct_timer gct_checker #(.AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_gct_timer.sv
`timescale 1ns/1ps
module sim_gct_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        we = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    gct_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .we_i(we),
        .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(12'h100, v); chk("R1 cnt lo", v, 0);
        rd(12'h104, v); chk("R1 cnt hi", v, 0);
        rd(12'h200, v); chk("R1 cmp lo", v, 0);
        rd(12'h240, v); chk("R1 ctrl", v, 0);
        rd(12'h24C, v); chk("R1 gen ws", v, 0);
        rd(12'h110, v); chk("R1 cnt ws", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
    endtask

    task automatic t_count;
        logic [31:0] v;
        ticks(3);
        rd(12'h100, v); chk("R2 stopped", v, 0);
        wr(12'h240, 32'h100);
        ticks(4);
        rd(12'h100, v); chk("R2 running", v, 4);
        @(negedge clk);
        we = 1'b1; addr = 12'h100; wdata = 32'd50; tick = 1'b1;
        @(negedge clk);
        we = 1'b0; tick = 1'b0;
        rd(12'h100, v); chk("R3 write beats tick", v, 50);
    endtask

    task automatic t_wrap;
        logic [31:0] v;
        wr(12'h240, 32'h0);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h104, 32'hFFFF_FFFF);
        wr(12'h240, 32'h100);
        ticks(1);
        rd(12'h100, v); chk("R3 wrap lo", v, 0);
        rd(12'h104, v); chk("R3 wrap hi", v, 0);
    endtask

    task automatic t_split;
        logic [31:0] h1, l, h2;
        wr(12'h240, 32'h0);
        wr(12'h100, 32'hFFFF_FFFF);
        wr(12'h104, 32'h0);
        wr(12'h240, 32'h100);
        rd(12'h104, h1);
        ticks(1);
        rd(12'h100, l);
        rd(12'h104, h2);
        chk("R4 first hi", h1, 0);
        chk("R4 lo after carry", l, 0);
        chk("R4 second hi", h2, 1);
    endtask

    task automatic t_match;
        logic [31:0] v;
        wr(12'h240, 32'h0);
        wr(12'h244, 32'h1);
        wr(12'h248, 32'h1);
        wr(12'h104, 32'h0);
        wr(12'h100, 32'd10);
        wr(12'h204, 32'h0);
        wr(12'h200, 32'd12);
        wr(12'h240, 32'h101);
        ticks(1);
        rd(12'h244, v); chk("R5 no early match", v, 0);
        ticks(1);
        chk("R7 irq not yet", {31'd0, irq}, 0);
        @(negedge clk);
        chk("R7 irq one cycle after match", {31'd0, irq}, 1);
        rd(12'h244, v); chk("R5 status set", v, 1);
        ticks(1);
        wr(12'h244, 32'h0);
        rd(12'h244, v); chk("R6 write zero keeps", v, 1);
        wr(12'h244, 32'h1);
        rd(12'h244, v); chk("R6 cleared", v, 0);
        chk("R6 irq low", {31'd0, irq}, 0);
        wr(12'h248, 32'h0);
        wr(12'h200, 32'd20);
        ticks(7);
        @(negedge clk);
        rd(12'h244, v); chk("R7 status while masked", v, 1);
        chk("R7 masked irq", {31'd0, irq}, 0);
        wr(12'h248, 32'h1);
        chk("R7 unmasked irq", {31'd0, irq}, 1);
        ticks(1);
        wr(12'h244, 32'h1);
    endtask

    task automatic t_autoinc;
        logic [31:0] v;
        wr(12'h240, 32'h0);
        wr(12'h244, 32'h1);
        wr(12'h100, 32'd100);
        wr(12'h200, 32'd105);
        wr(12'h208, 32'd5);
        wr(12'h240, 32'h103);
        ticks(5);
        @(negedge clk);
        rd(12'h244, v); chk("R8 first match", v, 1);
        rd(12'h200, v); chk("R8 cmp advanced", v, 110);
        wr(12'h244, 32'h1);
        rd(12'h244, v); chk("R8 cleared", v, 0);
        ticks(5);
        @(negedge clk);
        rd(12'h244, v); chk("R8 second match", v, 1);
        rd(12'h200, v); chk("R8 cmp advanced again", v, 115);
    endtask

    task automatic t_disable;
        logic [31:0] v;
        wr(12'h240, 32'h100);
        wr(12'h244, 32'h1);
        ticks(5);
        @(negedge clk);
        rd(12'h100, v); chk("R9 counter at cmp", v, 115);
        rd(12'h244, v); chk("R9 no status", v, 0);
        rd(12'h200, v); chk("R9 cmp unchanged", v, 115);
    endtask

    task automatic t_wstat;
        logic [31:0] v;
        wr(12'h240, 32'h0);
        wr(12'h110, 32'h3);
        wr(12'h24C, 32'h0001_0007);
        rd(12'h110, v); chk("R10 cnt ws cleared", v, 0);
        rd(12'h24C, v); chk("R10 gen ws cleared", v, 0);
        wr(12'h104, 32'h0);
        rd(12'h110, v); chk("R10 hi write ack", v, 2);
        wr(12'h100, 32'h0);
        rd(12'h110, v); chk("R10 lo write ack", v, 3);
        wr(12'h110, 32'h1);
        rd(12'h110, v); chk("R10 partial clear", v, 2);
        wr(12'h200, 32'h0);
        wr(12'h204, 32'h0);
        wr(12'h208, 32'h1);
        wr(12'h240, 32'h0);
        rd(12'h24C, v); chk("R10 gen ws all", v, 32'h0001_0007);
        wr(12'h24C, 32'h4);
        rd(12'h24C, v); chk("R10 gen ws partial clear", v, 32'h0001_0003);
    endtask

    task automatic t_ctrl;
        logic [31:0] v;
        wr(12'h240, 32'hFFFF_FFFF);
        rd(12'h240, v); chk("R11 ctrl readback", v, 32'h103);
        wr(12'h240, 32'h0);
        rd(12'h240, v); chk("R11 ctrl zero", v, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_count;
        t_wrap;
        t_split;
        t_match;
        t_autoinc;
        t_disable;
        t_wstat;
        t_ctrl;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule